// File: doc/BRIEF.md
# Shared-Memory Mailbox With Ownership Handoff

This block is a 256-bit mailbox aperture that sits between two agents: a requester that fills in a message and a responder that acts on it. The aperture holds eight 32-bit words. The top word is a protocol header, and bit 31 of that header records which agent currently owns the mailbox. While the requester owns it, the requester may write any word. Its write to the header word hands ownership to the responder and produces a one-cycle notification pulse. From then on, requester writes are dropped and flagged. The responder hands ownership back by writing a response header through its own port. That write always clears the owner bit.

Both agents read the aperture through their own combinational read ports. While the requester is held in its reset, every word reads as all ones on both ports and all writes are ignored. When that reset is released, the storage, the owner bit and the error flag come back as zero. This leaves the requester as owner.

The header layout is as follows:
- bits 2:0: message type
- bits 5:3: version
- bit 7: direction (0 = request, 1 = response)
- bits 15:8: status
- bit 24: requester-reset flag
- bit 31: owner

The block stores the header fields unaltered apart from the owner bit.

Top module: `mbox_handoff`

## Requirements
- R1: After `rst_n` is released, every word reads 0 on both ports, and `owner`, `handoff` and `drop_err` are 0.
- R2: A requester write to word 0..6 while `owner` is 0 is readable on both read ports from the next cycle. Other words keep their values.
- R3: A requester write to word 7 (the header) while `owner` is 0 stores bits 30:0 as written and sets bit 31 to 1, whatever bit 31 of the write data is. `owner` is 1 from the next cycle.
- R4: `handoff` is high for exactly one cycle. That cycle is the first cycle in which `owner` reads 1 after an accepted header write.
- R5: A requester write while `owner` is 1 changes no word. It sets `drop_err` from the next cycle, and `drop_err` stays set until the requester reset or `rst_n`.
- R6: A responder write while `owner` is 1 stores its bits 30:0 into word 7 and clears bit 31 whatever was written there. `owner` is 0 from the next cycle, and status (bits 15:8) and direction (bit 7) read back as written.
- R7: A responder write while `owner` is 0 changes no word.
- R8: While `req_rst` is high, both read ports return 0xFFFFFFFF at every address. Writes on both ports are ignored, and `handoff` stays 0.
- R9: After `req_rst` falls, every word reads 0, and `owner` and `drop_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_rst | input | 1 | Requester held in reset; aperture reads all ones |
| req_we | input | 1 | Requester write enable |
| req_waddr | input | 3 | Requester write word index |
| req_wdata | input | 32 | Requester write data |
| req_raddr | input | 3 | Requester read word index |
| req_rdata | output | 32 | Requester read data (combinational) |
| rsp_we | input | 1 | Responder header write enable |
| rsp_wdata | input | 32 | Responder header write data |
| rsp_raddr | input | 3 | Responder read word index |
| rsp_rdata | output | 32 | Responder read data (combinational) |
| owner | output | 1 | Current owner bit, 1 = responder |
| handoff | output | 1 | One-cycle pulse when ownership passes to the responder |
| drop_err | output | 1 | Sticky flag: a requester write was dropped |

## Verification
Every write takes effect at the next clock edge. Stored words, `owner`, `handoff` and `drop_err` are therefore due one cycle after the write is presented, and the bench drives on the falling edge and samples on the following falling edge. The read ports and the all-ones override are combinational, so they are checked a short delay after the address or `req_rst` changes, with no edge in between. The pulse is checked both in its due cycle and one cycle later to confirm it has fallen.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic       owner;      // 31
        logic [5:0] rsv_hi;     // 30:25
        logic       rst_flag;   // 24
        logic [7:0] rsv_mid;    // 23:16
        logic [7:0] status;     // 15:8
        logic       dir;        // 7
        logic       rsv_lo;     // 6
        logic [2:0] version;    // 5:3
        logic [2:0] kind;       // 2:0
    } hdr_t;
endpackage

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                req_acc,
    input  logic [AW-1:0]                       req_waddr,
    input  logic [WORD_W-1:0]                   req_wdata,
    input  logic                                rsp_acc,
    input  logic [WORD_W-1:0]                   rsp_wdata,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    words,
    output logic                                owner_bit
);
    localparam int unsigned HDR = NUM_WORDS - 1;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;
    hdr_t hdr_w;

    always_comb begin
        st_d  = st_q;
        hdr_w = hdr_t'(st_q.mem[HDR]);
        if (clr) begin
            st_d.mem = '0;
        end else if (req_acc) begin
            st_d.mem[req_waddr] = req_wdata;
            if (req_waddr == AW'(HDR)) begin
                hdr_w       = hdr_t'(req_wdata);
                hdr_w.owner = 1'b1;
                st_d.mem[HDR] = hdr_w;
            end
        end else if (rsp_acc) begin
            hdr_w       = hdr_t'(rsp_wdata);
            hdr_w.owner = 1'b0;
            st_d.mem[HDR] = hdr_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words     = st_q.mem;
    assign owner_bit = st_q.mem[HDR][WORD_W-1];

    // R5 / R7: with no accepted write and no clear, storage holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !req_acc && !rsp_acc) |=> $stable(st_q.mem));
    // R3: accepted header write always sets the owner bit
    a_r3_owner_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && req_acc && req_waddr == AW'(HDR)) |=> owner_bit);
endmodule

// File: rtl/mbox_owner.sv
module mbox_owner
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          owner_bit,
    input  logic          req_we,
    input  logic [AW-1:0] req_waddr,
    input  logic          rsp_we,
    output logic          req_acc,
    output logic          rsp_acc,
    output logic          handoff,
    output logic          drop_err
);
    localparam int unsigned HDR = NUM_WORDS - 1;

    typedef struct packed {
        logic pulse;
        logic err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        req_acc   = req_we && !clr && !owner_bit;
        rsp_acc   = rsp_we && !clr &&  owner_bit;
        st_d      = st_q;
        st_d.pulse = req_acc && (req_waddr == AW'(HDR));
        if (clr) st_d.err = 1'b0;
        else if (req_we && owner_bit) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign handoff  = st_q.pulse;
    assign drop_err = st_q.err;

    // R4: pulse lasts one cycle and coincides with a fresh owner bit
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |=> !handoff);
    a_r4_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> (owner_bit && !$past(owner_bit)));
    // R5: error flag sticks until requester reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_err && !clr) |=> drop_err);
    // R6: accepted responder write returns ownership
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_acc |=> !owner_bit);
    // R9: requester reset leaves clean state
    a_r9_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr) |-> (!owner_bit && !drop_err));
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic                              in_reset,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
    input  logic [AW-1:0]                     raddr,
    output logic [WORD_W-1:0]                 rdata
);
    always_comb begin
        if (in_reset) rdata = '1;
        else          rdata = words[raddr];
    end
endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rst,
    input  logic              req_we,
    input  logic [AW-1:0]     req_waddr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [AW-1:0]     req_raddr,
    output logic [WORD_W-1:0] req_rdata,
    input  logic              rsp_we,
    input  logic [WORD_W-1:0] rsp_wdata,
    input  logic [AW-1:0]     rsp_raddr,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              owner,
    output logic              handoff,
    output logic              drop_err
);
    localparam int unsigned NUM_RD = 2;

    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic owner_bit, req_acc, rsp_acc;
    logic [NUM_RD-1:0][AW-1:0]     rd_addr;
    logic [NUM_RD-1:0][WORD_W-1:0] rd_data;

    mbox_owner #(.NUM_WORDS(NUM_WORDS)) i_owner (
        .clk(clk), .rst_n(rst_n), .clr(req_rst), .owner_bit(owner_bit),
        .req_we(req_we), .req_waddr(req_waddr), .rsp_we(rsp_we),
        .req_acc(req_acc), .rsp_acc(rsp_acc),
        .handoff(handoff), .drop_err(drop_err)
    );

    mbox_store #(.NUM_WORDS(NUM_WORDS)) i_store (
        .clk(clk), .rst_n(rst_n), .clr(req_rst),
        .req_acc(req_acc), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .rsp_acc(rsp_acc), .rsp_wdata(rsp_wdata),
        .words(words), .owner_bit(owner_bit)
    );

    assign rd_addr[0] = req_raddr;
    assign rd_addr[1] = rsp_raddr;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mbox_rdport #(.NUM_WORDS(NUM_WORDS)) i_rd (
            .in_reset(req_rst), .words(words),
            .raddr(rd_addr[p]), .rdata(rd_data[p])
        );
    end

    assign req_rdata = rd_data[0];
    assign rsp_rdata = rd_data[1];
    assign owner     = owner_bit;

    // R8: no handoff notification while requester reset is held
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |=> !handoff);
    // R8: requester reset reads all ones at the requester port
    always_comb begin
        if (rst_n && req_rst) a_r8_ones: assert (req_rdata == '1);
    end
endmodule

// File: tb/test_mbox_handoff.sv
module test_mbox_handoff;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rst = 1'b0, req_we = 1'b0, rsp_we = 1'b0;
    logic [2:0] req_waddr = '0, req_raddr = '0, rsp_raddr = '0;
    logic [31:0] req_wdata = '0, rsp_wdata = '0, req_rdata, rsp_rdata;
    logic owner, handoff, drop_err;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_handoff i_mbox_handoff (
        .clk(clk), .rst_n(rst_n), .req_rst(req_rst),
        .req_we(req_we), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .req_raddr(req_raddr), .req_rdata(req_rdata),
        .rsp_we(rsp_we), .rsp_wdata(rsp_wdata),
        .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata),
        .owner(owner), .handoff(handoff), .drop_err(drop_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd_both(string tag, logic [2:0] a, logic [31:0] exp);
        req_raddr = a; rsp_raddr = a; #1;
        chk({tag, " req port"}, req_rdata, exp);
        chk({tag, " rsp port"}, rsp_rdata, exp);
    endtask

    // drive at negedge, take effect at next posedge, sample at following negedge
    task automatic req_write(logic [2:0] a, logic [31:0] d);
        req_we = 1; req_waddr = a; req_wdata = d;
        @(negedge clk); req_we = 0;
    endtask

    task automatic rsp_write(logic [31:0] d);
        rsp_we = 1; rsp_wdata = d;
        @(negedge clk); rsp_we = 0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_both("R1 word", 3'(a), 32'h0);
        chk("R1 owner", 32'(owner), 0);
        chk("R1 handoff", 32'(handoff), 0);
        chk("R1 drop_err", 32'(drop_err), 0);
    endtask

    task automatic t_payload;
        req_write(3'd0, 32'hA5A5_0001);
        req_write(3'd6, 32'h1234_5678);
        req_write(3'd3, 32'hFFFF_FFFF);
        rd_both("R2 w0", 3'd0, 32'hA5A5_0001);
        rd_both("R2 w6", 3'd6, 32'h1234_5678);
        rd_both("R2 w3", 3'd3, 32'hFFFF_FFFF);
        rd_both("R2 w1 untouched", 3'd1, 32'h0);
        chk("R2 owner stays", 32'(owner), 0);
        chk("R2 no pulse", 32'(handoff), 0);
    endtask

    task automatic t_header;
        // request: kind=1, version=0, dir=0, reset flag bit 24 set, bit 31 written 0
        req_write(3'd7, 32'h0100_0001);
        chk("R3 owner set", 32'(owner), 1);
        chk("R4 pulse due", 32'(handoff), 1);
        rd_both("R3 header bit31 forced", 3'd7, 32'h8100_0001);
        @(negedge clk);
        chk("R4 pulse gone", 32'(handoff), 0);
        chk("R3 owner held", 32'(owner), 1);
    endtask

    task automatic t_drop;
        chk("R5 err clear before", 32'(drop_err), 0);
        req_write(3'd0, 32'hDEAD_BEEF);
        chk("R5 err set", 32'(drop_err), 1);
        rd_both("R5 w0 unchanged", 3'd0, 32'hA5A5_0001);
        req_write(3'd7, 32'h0000_0002);
        rd_both("R5 header unchanged", 3'd7, 32'h8100_0001);
        chk("R5 no pulse on drop", 32'(handoff), 0);
        @(negedge clk);
        chk("R5 err sticky", 32'(drop_err), 1);
    endtask

    task automatic t_response;
        // response: kind=1, dir=1, status=0x5A, bit 31 written as 1
        rsp_write(32'h8000_5A81);
        chk("R6 owner released", 32'(owner), 0);
        rd_both("R6 header", 3'd7, 32'h0000_5A81);
        chk("R6 err still sticky (R5)", 32'(drop_err), 1);
    endtask

    task automatic t_rsp_ignored;
        rsp_write(32'h0000_0F82);
        rd_both("R7 header unchanged", 3'd7, 32'h0000_5A81);
        chk("R7 owner stays", 32'(owner), 0);
        req_write(3'd1, 32'h0BAD_F00D);
        rd_both("R2 write after return", 3'd1, 32'h0BAD_F00D);
    endtask

    task automatic t_req_reset;
        req_rst = 1; #1;
        rd_both("R8 w0 ones", 3'd0, 32'hFFFF_FFFF);
        rd_both("R8 w7 ones", 3'd7, 32'hFFFF_FFFF);
        req_write(3'd7, 32'h0000_0001);
        chk("R8 no pulse", 32'(handoff), 0);
        rd_both("R8 w5 ones", 3'd5, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R8 no pulse later", 32'(handoff), 0);
        req_rst = 0; #1;
        for (int a = 0; a < 8; a++) rd_both("R9 word", 3'(a), 32'h0);
        chk("R9 owner", 32'(owner), 0);
        chk("R9 drop_err", 32'(drop_err), 0);
        req_write(3'd2, 32'h0000_0042);
        rd_both("R9 writable", 3'd2, 32'h0000_0042);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_payload();
        t_header();
        t_drop();
        t_response();
        t_rsp_ignored();
        t_req_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule